// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks where each of the two ALU operands comes from in the execute stage of a five-stage pipeline. Each operand has a source register index. The block compares that index against the destination index of the instruction one stage ahead, which has an ALU result waiting. It also compares against the destination of the instruction two stages ahead, which has a result waiting to be written back. A comparison counts only when that older instruction really writes a register. When a comparison hits, the newer value is steered onto the operand in place of the stale register-file read.

The unit is purely combinational. It produces a 2-bit select for each operand, and it contains the two three-way operand multiplexers those selects drive, so the selected data can be checked at its ports. The register index zero is hard-wired to zero, so it is never treated as a forwarding source. When both older stages write the operand's register, the nearer one holds the newer value and wins.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage qualifies for an operand, its select is 2'b00 and the operand equals the register-file read data for that operand.
- R2: When the memory-stage write enable is 1, the memory-stage destination is nonzero and it equals the operand's source index, the select is 2'b10 and the operand equals the memory-stage ALU result.
- R3: When the write-back-stage write enable is 1, the write-back destination is nonzero and it equals the operand's source index, and R2 does not apply, the select is 2'b01 and the operand equals the write-back result.
- R4: When both older stages qualify for the same operand, the memory stage wins: the select is 2'b10.
- R5: A stage whose write enable is 0 never provides an operand, even if its destination index matches.
- R6: A destination index of zero never provides an operand, even with its write enable set and a source index of zero.
- R7: The two operands are resolved independently, and one older stage may feed both operands in the same cycle.
- R8: A select output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | REG_W | Source register index of operand A in the execute stage |
| src_b_idx | input | REG_W | Source register index of operand B in the execute stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst_idx | input | REG_W | Memory-stage destination register index |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| wb_dst_idx | input | REG_W | Write-back-stage destination register index |
| rf_a_data | input | DATA_W | Register-file read data for operand A |
| rf_b_data | input | DATA_W | Register-file read data for operand B |
| mem_alu_data | input | DATA_W | ALU result held in the memory stage |
| wb_res_data | input | DATA_W | Result held in the write-back stage (load data or ALU result) |
| sel_a | output | 2 | Source select for operand A (00 file, 01 write-back, 10 memory stage) |
| sel_b | output | 2 | Source select for operand B (same encoding) |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
Every output of this unit is due in the same cycle as the index, enable and data inputs that produce it, because no register lies between them. The bench therefore applies a new set of inputs just after a rising edge and compares both selects and both operands half a period later, at the falling edge. The expected values come from a behavioural reference that is recomputed from the requirements each cycle. Fresh random data words are used on every cycle, so a wrong source cannot match the expected operand by accident.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_FILE = 2'b00,
        SRC_WB   = 2'b01,
        SRC_MEM  = 2'b10
    } fwd_src_e;

    // Nearer stage holds the newer value, so it is checked first.
    function automatic fwd_src_e pick_src(input logic mem_hit, input logic wb_hit);
        if (mem_hit)     return SRC_MEM;
        else if (wb_hit) return SRC_WB;
        else             return SRC_FILE;
    endfunction

endpackage

// File: rtl/fwd_detect.sv
module fwd_detect
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic             mem_wr_en,
    input  logic [REG_W-1:0] mem_dst_idx,
    input  logic             wb_wr_en,
    input  logic [REG_W-1:0] wb_dst_idx,
    output fwd_src_e         src_sel
);

    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    function automatic logic stage_hit(input logic en,
                                       input logic [REG_W-1:0] dst,
                                       input logic [REG_W-1:0] src);
        return en && (dst != ZERO_IDX) && (dst == src);
    endfunction

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = stage_hit(mem_wr_en, mem_dst_idx, src_idx);
        wb_hit  = stage_hit(wb_wr_en, wb_dst_idx, src_idx);
        src_sel = pick_src(mem_hit, wb_hit);
    end

endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_src_e          src_sel,
    input  logic [DATA_W-1:0] file_data,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        case (src_sel)
            SRC_MEM: opnd = mem_data;
            SRC_WB:  opnd = wb_data;
            default: opnd = file_data;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src_a_idx,
    input  logic [REG_W-1:0]  src_b_idx,
    input  logic              mem_wr_en,
    input  logic [REG_W-1:0]  mem_dst_idx,
    input  logic              wb_wr_en,
    input  logic [REG_W-1:0]  wb_dst_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic [DATA_W-1:0] mem_alu_data,
    input  logic [DATA_W-1:0] wb_res_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [REG_W-1:0]  src_idx  [NUM_OPND];
    logic [DATA_W-1:0] file_dat [NUM_OPND];
    logic [DATA_W-1:0] opnd_dat [NUM_OPND];
    fwd_src_e          src_sel  [NUM_OPND];

    assign src_idx[0]  = src_a_idx;
    assign src_idx[1]  = src_b_idx;
    assign file_dat[0] = rf_a_data;
    assign file_dat[1] = rf_b_data;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_detect #(.REG_W(REG_W)) u_det (
            .src_idx     (src_idx[g]),
            .mem_wr_en   (mem_wr_en),
            .mem_dst_idx (mem_dst_idx),
            .wb_wr_en    (wb_wr_en),
            .wb_dst_idx  (wb_dst_idx),
            .src_sel     (src_sel[g])
        );

        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .src_sel   (src_sel[g]),
            .file_data (file_dat[g]),
            .wb_data   (wb_res_data),
            .mem_data  (mem_alu_data),
            .opnd      (opnd_dat[g])
        );
    end

    assign sel_a  = src_sel[0];
    assign sel_b  = src_sel[1];
    assign opnd_a = opnd_dat[0];
    assign opnd_b = opnd_dat[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  src_a_idx,
    input logic [REG_W-1:0]  src_b_idx,
    input logic              mem_wr_en,
    input logic [REG_W-1:0]  mem_dst_idx,
    input logic              wb_wr_en,
    input logic [REG_W-1:0]  wb_dst_idx,
    input logic [DATA_W-1:0] rf_a_data,
    input logic [DATA_W-1:0] rf_b_data,
    input logic [DATA_W-1:0] mem_alu_data,
    input logic [DATA_W-1:0] wb_res_data,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    always_comb begin
        a_r8_sel_a_legal: assert (sel_a != 2'b11) else $error("sel_a illegal");
        a_r8_sel_b_legal: assert (sel_b != 2'b11) else $error("sel_b illegal");

        a_r5_mem_off_a: assert (mem_wr_en || sel_a != 2'b10) else $error("A from idle mem stage");
        a_r5_mem_off_b: assert (mem_wr_en || sel_b != 2'b10) else $error("B from idle mem stage");
        a_r5_wb_off_a:  assert (wb_wr_en  || sel_a != 2'b01) else $error("A from idle wb stage");
        a_r5_wb_off_b:  assert (wb_wr_en  || sel_b != 2'b01) else $error("B from idle wb stage");

        a_r6_zero_mem_a: assert (mem_dst_idx != '0 || sel_a != 2'b10) else $error("A from mem reg zero");
        a_r6_zero_wb_a:  assert (wb_dst_idx  != '0 || sel_a != 2'b01) else $error("A from wb reg zero");
        a_r6_zero_mem_b: assert (mem_dst_idx != '0 || sel_b != 2'b10) else $error("B from mem reg zero");
        a_r6_zero_wb_b:  assert (wb_dst_idx  != '0 || sel_b != 2'b01) else $error("B from wb reg zero");

        a_r4_prio_a: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_a_idx)
                             || sel_a == 2'b10) else $error("A lost mem priority");
        a_r4_prio_b: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_b_idx)
                             || sel_b == 2'b10) else $error("B lost mem priority");

        a_r2_data_a: assert (sel_a != 2'b10 || opnd_a == mem_alu_data) else $error("A mem data");
        a_r3_data_a: assert (sel_a != 2'b01 || opnd_a == wb_res_data)  else $error("A wb data");
        a_r1_data_a: assert (sel_a != 2'b00 || opnd_a == rf_a_data)    else $error("A file data");
        a_r2_data_b: assert (sel_b != 2'b10 || opnd_b == mem_alu_data) else $error("B mem data");
        a_r3_data_b: assert (sel_b != 2'b01 || opnd_b == wb_res_data)  else $error("B wb data");
        a_r1_data_b: assert (sel_b != 2'b00 || opnd_b == rf_b_data)    else $error("B file data");
    end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
    .src_a_idx    (src_a_idx),
    .src_b_idx    (src_b_idx),
    .mem_wr_en    (mem_wr_en),
    .mem_dst_idx  (mem_dst_idx),
    .wb_wr_en     (wb_wr_en),
    .wb_dst_idx   (wb_dst_idx),
    .rf_a_data    (rf_a_data),
    .rf_b_data    (rf_b_data),
    .mem_alu_data (mem_alu_data),
    .wb_res_data  (wb_res_data),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b)
);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;

    localparam int RW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic [RW-1:0] src_a_idx = '0, src_b_idx = '0, mem_dst_idx = '0, wb_dst_idx = '0;
    logic          mem_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [DW-1:0] rf_a_data = '0, rf_b_data = '0, mem_alu_data = '0, wb_res_data = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    fwd_unit #(.REG_W(RW), .DATA_W(DW)) u0 (.*);

    // Behavioural reference: which stage feeds a source index.
    function automatic int ref_src(input logic [RW-1:0] s);
        if (mem_wr_en && mem_dst_idx != 0 && mem_dst_idx == s) return 2;
        if (wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == s)    return 1;
        return 0;
    endfunction

    function automatic string ref_tag(input logic [RW-1:0] s, input int r);
        bit wbh = wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == s;
        if (r == 2 && wbh) return "R4";
        if (r == 2) return "R2";
        if (r == 1) return "R3";
        if (s == 0 && ((mem_wr_en && mem_dst_idx == 0) || (wb_wr_en && wb_dst_idx == 0))) return "R6";
        if ((!mem_wr_en && mem_dst_idx == s) || (!wb_wr_en && wb_dst_idx == s)) return "R5";
        return "R1";
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string ovr);
        int ra = ref_src(src_a_idx);
        int rb = ref_src(src_b_idx);
        string ta = (ovr != "") ? ovr : ref_tag(src_a_idx, ra);
        string tb = (ovr != "") ? ovr : ref_tag(src_b_idx, rb);
        logic [DW-1:0] ea = (ra == 2) ? mem_alu_data : (ra == 1) ? wb_res_data : rf_a_data;
        logic [DW-1:0] eb = (rb == 2) ? mem_alu_data : (rb == 1) ? wb_res_data : rf_b_data;
        chk(ta, "sel_a", {30'd0, sel_a}, ra);
        chk(tb, "sel_b", {30'd0, sel_b}, rb);
        chk(ta, "opnd_a", opnd_a, ea);
        chk(tb, "opnd_b", opnd_b, eb);
        chk("R8", "sel_a/sel_b never 11", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, '0);
    endtask

    task automatic step(input logic [RW-1:0] sa, input logic [RW-1:0] sb,
                        input logic me, input logic [RW-1:0] md,
                        input logic we, input logic [RW-1:0] wd, input string ovr);
        @(posedge clk);
        src_a_idx = sa; src_b_idx = sb;
        mem_wr_en = me; mem_dst_idx = md;
        wb_wr_en = we;  wb_dst_idx = wd;
        rf_a_data = $urandom; rf_b_data = $urandom;
        mem_alu_data = $urandom; wb_res_data = $urandom;
        @(negedge clk);
        compare(ovr);
    endtask

    initial begin
        // Idle inputs: both operands from the file (R1).
        @(negedge clk);
        chk("R1", "idle sel_a", {30'd0, sel_a}, 0);
        chk("R1", "idle sel_b", {30'd0, sel_b}, 0);

        step(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd9, "R1");   // no match
        step(5'd7, 5'd4, 1'b1, 5'd7, 1'b0, 5'd0, "");     // R2 on A
        step(5'd4, 5'd9, 1'b0, 5'd0, 1'b1, 5'd9, "");     // R3 on B
        step(5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6, "R4");   // both stages, both operands
        step(5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8, "R5");   // enables off
        step(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R6");   // register zero
        step(5'd2, 5'd2, 1'b1, 5'd2, 1'b0, 5'd0, "R7");   // one stage feeds both
        step(5'd2, 5'd5, 1'b1, 5'd2, 1'b1, 5'd5, "R7");   // A from mem, B from wb
        step(5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 5'd5, "R5");   // mem off, wb supplies

        for (int i = 0; i < 600; i++) begin
            step(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                 1'($urandom), 5'($urandom_range(0, 3)),
                 1'($urandom), 5'($urandom_range(0, 3)), "");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule